// File: doc/BRIEF.md
# Codec Input Frame Serializer

This block is the transmit side of a codec on a serial audio link. The codec sends one input frame back to the link controller each frame period. Everything runs on the rising edge of the bit clock. A frame begins when the frame-sync input is sampled high after having been low. The block then drives one bit per bit-clock rising edge on a single serial output, MSB first. A frame is 256 bits long: a 16-bit tag, followed by twelve 20-bit slots.

The tag reports codec readiness and which slots hold valid content. Slot 1 returns the index of the control register read by the controller's request in the previous output frame. It also carries active-low sample-request flags, which the controller uses for variable-rate audio. Slot 2 returns the data read from that register. Slots 3 and 4 carry the left and right 20-bit PCM samples. Every reserved bit and every unused slot is driven as zero.

All inputs are sampled on the edge that starts a frame. The frame in flight therefore cannot be corrupted by later input changes. Until the codec reports ready, the whole frame is sent as zeros.

Top module: `codec_frame_serializer`

## Requirements
- R1: While reset is asserted, and after it until the first frame start, `ser_out` is 0.
- R2: A frame starts on a rising clock edge at which `sync` is 1 and was 0 at the previous edge. That edge drives tag bit 15. Each of the next 255 edges drives the next lower bit of the 256-bit frame, MSB first.
- R3: Tag bit 15 is `codec_ready`. Bits 14 and 13 are both `echo_valid`. Bit 12 is `pcm_left_valid` and bit 11 is `pcm_right_valid`. Bits 10:0 are 0.
- R4: In slot 1, bit 19 is 0. Bits 18:12 hold `echo_index` when `echo_valid` is 1, and 0 otherwise. Bits 11, 10, 8, 7, 6 and 5 carry `slot_req_n[0]` through `slot_req_n[5]` in that order; these request samples for slots 3, 4, 6, 7, 8 and 9, and 0 means "send data". All other slot 1 bits are 0.
- R5: In slot 2, bits 19:4 hold `echo_data` when `echo_valid` is 1, and 0 otherwise. Bits 3:0 are 0.
- R6: Slot 3 holds `pcm_left` when `pcm_left_valid` is 1, and slot 4 holds `pcm_right` when `pcm_right_valid` is 1. Each is 0 otherwise.
- R7: Slots 5 to 12 are all 0.
- R8: The frame content is taken from the inputs at the start edge. Input changes after that edge have no effect on the frame.
- R9: When `codec_ready` is 0 at the start edge, all 256 bits of the frame, tag included, are 0.
- R10: After the last bit of a frame, `ser_out` stays 0 until the next frame start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bit_clk | input | 1 | Bit clock; all logic uses its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| sync | input | 1 | Frame sync; a low-to-high change starts a frame |
| codec_ready | input | 1 | Codec ready flag |
| echo_valid | input | 1 | Register index and read data are valid |
| echo_index | input | 7 | Index of the register read last frame |
| echo_data | input | 16 | Data read from that register |
| slot_req_n | input | 6 | Active-low sample requests for slots 3,4,6,7,8,9 |
| pcm_left | input | 20 | Left PCM sample |
| pcm_left_valid | input | 1 | Left sample valid |
| pcm_right | input | 20 | Right PCM sample |
| pcm_right_valid | input | 1 | Right sample valid |
| ser_out | output | 1 | Serial input-frame data |

## Verification
The assertions take for granted that `sync` and all data inputs are synchronous to the bit clock. They also assume that reset is held low from time zero, so the frame-start detector has a defined history. The bench drives every input on the falling clock edge and raises `sync` for 16 bit times once every 256 bit times. It never starts a frame before the previous one has ended. It scrambles all data inputs once `sync` falls, which exercises frame capture without breaking those assumptions.

// File: rtl/cfs_pkg.sv
// Package: shared sizes for the codec input frame serializer.
// Assumes a 16-bit tag followed by twelve 20-bit slots.
package cfs_pkg;
    localparam int TAG_W    = 16;
    localparam int SLOT_W   = 20;
    localparam int N_SLOTS  = 12;
    localparam int FRAME_W  = TAG_W + SLOT_W * N_SLOTS;
    localparam int IDX_W    = 7;
    localparam int RDATA_W  = 16;
    localparam int PCM_W    = 20;
    localparam int N_REQ    = 6;

    // Slot 1 bit position of request flag k (slots 3,4,6,7,8,9 in order).
    function automatic int req_bit_pos(input int k);
        case (k)
            0:       return 11;
            1:       return 10;
            2:       return 8;
            3:       return 7;
            4:       return 6;
            default: return 5;
        endcase
    endfunction
endpackage

// File: rtl/cfs_frame_pack.sv
// Module: cfs_frame_pack
// Builds the full input frame, combinationally, from the live inputs.
// The result is only meaningful at the frame-start edge, where the
// shifter loads it. A codec that is not ready yields an all-zero frame.
module cfs_frame_pack
    import cfs_pkg::*;
#(
    parameter int TAG_BITS  = TAG_W,
    parameter int SLOT_BITS = SLOT_W,
    parameter int SLOTS     = N_SLOTS,
    parameter int IDX_BITS  = IDX_W,
    parameter int DAT_BITS  = RDATA_W,
    parameter int PCM_BITS  = PCM_W,
    parameter int REQS      = N_REQ
) (
    input  logic                                 ready,
    input  logic                                 echo_valid,
    input  logic [IDX_BITS-1:0]                  echo_index,
    input  logic [DAT_BITS-1:0]                  echo_data,
    input  logic [REQS-1:0]                      slot_req_n,
    input  logic [PCM_BITS-1:0]                  pcm_left,
    input  logic                                 pcm_left_valid,
    input  logic [PCM_BITS-1:0]                  pcm_right,
    input  logic                                 pcm_right_valid,
    output logic [TAG_BITS+SLOT_BITS*SLOTS-1:0]  frame
);
    localparam int LEN = TAG_BITS + SLOT_BITS * SLOTS;

    logic [TAG_BITS-1:0]  tag;
    logic [SLOT_BITS-1:0] slot_stat_addr;
    logic [SLOT_BITS-1:0] slot_stat_data;

    // Tag: ready and per-slot validity flags in the top five bits.
    always_comb begin
        tag = '0;
        tag[TAG_BITS-1] = ready;
        tag[TAG_BITS-2] = echo_valid;
        tag[TAG_BITS-3] = echo_valid;
        tag[TAG_BITS-4] = pcm_left_valid;
        tag[TAG_BITS-5] = pcm_right_valid;
    end

    // Slot 1: echoed register index plus active-low sample requests.
    always_comb begin
        slot_stat_addr = '0;
        if (echo_valid)
            slot_stat_addr[SLOT_BITS-2 -: IDX_BITS] = echo_index;
        for (int k = 0; k < REQS; k++)
            slot_stat_addr[req_bit_pos(k)] = slot_req_n[k];
    end

    // Slot 2: register read data, MSB-justified, low nibble zero.
    always_comb begin
        slot_stat_data = '0;
        if (echo_valid)
            slot_stat_data[SLOT_BITS-1 -: DAT_BITS] = echo_data;
    end

    assign frame[LEN-1 -: TAG_BITS] = ready ? tag : '0;

    // One slot field per iteration; the slot number picks its content.
    for (genvar s = 1; s <= SLOTS; s++) begin : g_slot
        localparam int TOP = LEN - TAG_BITS - SLOT_BITS * (s - 1) - 1;
        if (s == 1) begin : g_addr
            assign frame[TOP -: SLOT_BITS] = ready ? slot_stat_addr : '0;
        end else if (s == 2) begin : g_data
            assign frame[TOP -: SLOT_BITS] = ready ? slot_stat_data : '0;
        end else if (s == 3) begin : g_left
            assign frame[TOP -: SLOT_BITS] =
                (ready && pcm_left_valid) ? SLOT_BITS'(pcm_left) : '0;
        end else if (s == 4) begin : g_right
            assign frame[TOP -: SLOT_BITS] =
                (ready && pcm_right_valid) ? SLOT_BITS'(pcm_right) : '0;
        end else begin : g_zero
            assign frame[TOP -: SLOT_BITS] = '0;
        end
    end
endmodule

// File: rtl/cfs_shifter.sv
// Module: cfs_shifter
// Detects the sync rising edge, loads the frame and shifts it out MSB
// first, one bit per bit-clock edge. Zeros follow the last bit.
// Assumes sync is synchronous to bit_clk.
module cfs_shifter #(
    parameter int LEN = 256
) (
    input  logic           bit_clk,
    input  logic           rst_n,
    input  logic           sync,
    input  logic [LEN-1:0] frame_in,
    output logic           frame_start,
    output logic           ser_out
);
    localparam int CNT_W = $clog2(LEN + 1);

    logic           sync_q;
    logic [LEN-1:0] shreg;
    logic [CNT_W-1:0] bits_left;
    logic           active;

    assign frame_start = sync & ~sync_q;
    assign active      = (bits_left != '0);
    assign ser_out     = shreg[LEN-1];

    // Remember sync from the previous edge for rise detection.
    always_ff @(posedge bit_clk) begin
        if (!rst_n) sync_q <= 1'b0;
        else        sync_q <= sync;
    end

    // Load the frame at start, else shift toward the MSB, filling zeros.
    always_ff @(posedge bit_clk) begin
        if (!rst_n)           shreg <= '0;
        else if (frame_start) shreg <= frame_in;
        else                  shreg <= {shreg[LEN-2:0], 1'b0};
    end

    // Count the bits of the current frame still on the line.
    always_ff @(posedge bit_clk) begin
        if (!rst_n)              bits_left <= '0;
        else if (frame_start)    bits_left <= CNT_W'(LEN);
        else if (active)         bits_left <= bits_left - 1'b1;
    end

    // R10: outside a frame the line is low.
    a_r10_idle_low: assert property (@(posedge bit_clk) disable iff (!rst_n)
        !active |-> !ser_out);

    // R10: with no new sync rise, an idle shifter stays idle.
    a_r10_stay_idle: assert property (@(posedge bit_clk) disable iff (!rst_n)
        (!active && !frame_start) |=> !active);
endmodule

// File: rtl/codec_frame_serializer.sv
// Module: codec_frame_serializer (top)
// Codec-side serializer for the input frame: tag, echoed register
// index/data, sample requests and stereo PCM, on one serial line.
// Assumes all inputs are synchronous to the rising edge of bit_clk.
module codec_frame_serializer
    import cfs_pkg::*;
(
    input  logic               bit_clk,
    input  logic               rst_n,
    input  logic               sync,
    input  logic               codec_ready,
    input  logic               echo_valid,
    input  logic [IDX_W-1:0]   echo_index,
    input  logic [RDATA_W-1:0] echo_data,
    input  logic [N_REQ-1:0]   slot_req_n,
    input  logic [PCM_W-1:0]   pcm_left,
    input  logic               pcm_left_valid,
    input  logic [PCM_W-1:0]   pcm_right,
    input  logic               pcm_right_valid,
    output logic               ser_out
);
    logic [FRAME_W-1:0] frame;
    logic               frame_start;

    cfs_frame_pack u_pack (
        .ready           (codec_ready),
        .echo_valid      (echo_valid),
        .echo_index      (echo_index),
        .echo_data       (echo_data),
        .slot_req_n      (slot_req_n),
        .pcm_left        (pcm_left),
        .pcm_left_valid  (pcm_left_valid),
        .pcm_right       (pcm_right),
        .pcm_right_valid (pcm_right_valid),
        .frame           (frame)
    );

    cfs_shifter #(.LEN(FRAME_W)) u_shift (
        .bit_clk     (bit_clk),
        .rst_n       (rst_n),
        .sync        (sync),
        .frame_in    (frame),
        .frame_start (frame_start),
        .ser_out     (ser_out)
    );

    // R2: the first bit after a start is the ready flag seen at that edge.
    a_r2_first_bit: assert property (@(posedge bit_clk) disable iff (!rst_n)
        frame_start |=> (ser_out == $past(codec_ready)));

    // R9: a frame started while not ready begins with a zero.
    a_r9_not_ready: assert property (@(posedge bit_clk) disable iff (!rst_n)
        (frame_start && !codec_ready) |=> !ser_out);
endmodule

// File: tb/test_codec_frame_serializer.sv
module test_codec_frame_serializer;
    logic        bit_clk = 1'b0;
    logic        rst_n;
    logic        sync;
    logic        codec_ready;
    logic        echo_valid;
    logic [6:0]  echo_index;
    logic [15:0] echo_data;
    logic [5:0]  slot_req_n;
    logic [19:0] pcm_left;
    logic        pcm_left_valid;
    logic [19:0] pcm_right;
    logic        pcm_right_valid;
    logic        ser_out;

    int total = 0;
    int bad   = 0;
    bit finished = 0;
    bit mon_busy = 0;
    logic [255:0] exp_q[$];

    always #2.5 bit_clk = ~bit_clk;

    codec_frame_serializer i_codec_frame_serializer (
        .bit_clk(bit_clk), .rst_n(rst_n), .sync(sync),
        .codec_ready(codec_ready), .echo_valid(echo_valid),
        .echo_index(echo_index), .echo_data(echo_data),
        .slot_req_n(slot_req_n), .pcm_left(pcm_left),
        .pcm_left_valid(pcm_left_valid), .pcm_right(pcm_right),
        .pcm_right_valid(pcm_right_valid), .ser_out(ser_out)
    );

    task automatic chk(input string req, input logic [255:0] got, input logic [255:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    // Reference frame computed from the requirements.
    function automatic logic [255:0] model(input logic rdy, input logic ev,
            input logic [6:0] idx, input logic [15:0] dat, input logic [5:0] rq,
            input logic lv, input logic [19:0] l, input logic rv, input logic [19:0] r);
        logic [255:0] f = '0;
        if (rdy) begin
            f[255] = 1'b1; f[254] = ev; f[253] = ev; f[252] = lv; f[251] = rv;
            if (ev) begin f[238:232] = idx; f[219:204] = dat; end
            f[231] = rq[0]; f[230] = rq[1]; f[228] = rq[2];
            f[227] = rq[3]; f[226] = rq[4]; f[225] = rq[5];
            if (lv) f[199:180] = l;
            if (rv) f[179:160] = r;
        end
        return f;
    endfunction

    // Driver: set inputs, push expectation, run one 256-bit frame period.
    task automatic send(input logic rdy, input logic ev, input logic [6:0] idx,
            input logic [15:0] dat, input logic [5:0] rq, input logic lv,
            input logic [19:0] l, input logic rv, input logic [19:0] r);
        @(negedge bit_clk);
        codec_ready = rdy; echo_valid = ev; echo_index = idx; echo_data = dat;
        slot_req_n = rq; pcm_left_valid = lv; pcm_left = l;
        pcm_right_valid = rv; pcm_right = r;
        exp_q.push_back(model(rdy, ev, idx, dat, rq, lv, l, rv, r));
        sync = 1'b1;
        repeat (16) @(negedge bit_clk);
        sync = 1'b0;
        // R8: scramble every input mid-frame.
        codec_ready = ~rdy; echo_valid = ~ev; echo_index = 7'($urandom);
        echo_data = 16'($urandom); slot_req_n = ~rq; pcm_left = 20'($urandom);
        pcm_left_valid = ~lv; pcm_right = 20'($urandom); pcm_right_valid = ~rv;
        repeat (240) @(negedge bit_clk);
    endtask

    // Monitor: detect frame start, collect 256 bits, compare per field.
    initial begin
        logic prev = 1'b0;
        forever begin
            @(posedge bit_clk);
            if (rst_n === 1'b1 && sync === 1'b1 && !prev) begin
                logic [255:0] got;
                logic [255:0] e;
                mon_busy = 1;
                for (int i = 255; i >= 0; i--) begin
                    @(negedge bit_clk);
                    got[i] = ser_out;
                end
                if (exp_q.size() == 0) begin
                    chk("R2 unexpected frame", got, '0);
                end else begin
                    e = exp_q.pop_front();
                    if (e[255] == 1'b0) begin
                        chk("R9 not-ready frame", got, e);
                    end else begin
                        chk("R3 tag", {240'b0, got[255:240]}, {240'b0, e[255:240]});
                        chk("R4 slot1", {236'b0, got[239:220]}, {236'b0, e[239:220]});
                        chk("R5 slot2", {236'b0, got[219:200]}, {236'b0, e[219:200]});
                        chk("R6 pcm", {216'b0, got[199:160]}, {216'b0, e[199:160]});
                        chk("R7 zero slots", {96'b0, got[159:0]}, {96'b0, e[159:0]});
                        chk("R2 R8 whole frame", got, e);
                    end
                end
                prev = 1'b0;
                mon_busy = 0;
            end else begin
                prev = sync;
            end
        end
    end

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        #(5.0 * 200000);
        total++; bad++;
        $display("FAIL watchdog expired got=hung exp=done");
        finish_run();
    end

    initial begin
        logic line_seen;
        rst_n = 1'b0; sync = 1'b0; codec_ready = 1'b0; echo_valid = 1'b0;
        echo_index = '0; echo_data = '0; slot_req_n = '0; pcm_left = '0;
        pcm_left_valid = 1'b0; pcm_right = '0; pcm_right_valid = 1'b0;
        repeat (4) @(negedge bit_clk);
        chk("R1 in reset", {255'b0, ser_out}, '0);
        rst_n = 1'b1;
        line_seen = 1'b0;
        repeat (8) begin
            @(negedge bit_clk);
            line_seen = line_seen | ser_out;
        end
        chk("R1 after reset", {255'b0, line_seen}, '0);

        send(1'b0, 1'b1, 7'h33, 16'hA5A5, 6'b000000, 1'b1, 20'hFFFFF, 1'b1, 20'h55555);
        send(1'b1, 1'b1, 7'h5A, 16'hBEEF, 6'b000000, 1'b1, 20'hABCDE, 1'b1, 20'h12345);
        send(1'b1, 1'b0, 7'h7F, 16'hFFFF, 6'b111111, 1'b0, 20'hFFFFF, 1'b0, 20'hFFFFF);
        send(1'b1, 1'b1, 7'h7F, 16'hFFFF, 6'b101010, 1'b1, 20'hFFFFF, 1'b0, 20'h0F0F0);
        send(1'b1, 1'b1, 7'h00, 16'h0001, 6'b010101, 1'b0, 20'h00001, 1'b1, 20'h80000);

        wait (!mon_busy && exp_q.size() == 0);
        line_seen = 1'b0;
        repeat (20) begin
            @(negedge bit_clk);
            line_seen = line_seen | ser_out;
        end
        chk("R10 idle after frame", {255'b0, line_seen}, '0);
        finish_run();
    end
endmodule